// File: doc/BRIEF.md
# Test-Port Wide-Word Access Sequencer

This block turns one 64-bit read or write request into the fixed series of register accesses needed to reach a memory that is only visible through a test port. The port has a command register and two 32-bit data registers. The address is scattered into a command word. Write data is staged in the data registers before the command is issued. Read data is collected from the data registers after the command has taken effect. Every transaction ends by returning the command register to zero, so that nothing else that later shares the port sees a stale command.

Requests are accepted only while the sequencer is idle. Once a sequence starts it runs to completion without interruption. Addresses are checked against a code-region limit set by a parameter. An out-of-range write is discarded, and an out-of-range read returns zero. In both cases the port is not touched. Completion is signalled by a single-cycle done pulse, which carries the read result.

Top module: `wide_port_seq`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_done` is 0, `rsp_rdata` is 0, and neither `port_wr` nor `port_rd` is asserted.
- R2: The command word is 40 bits wide. Address bits 14 and 10:3 stay at the same positions. Address bit 15 appears at both bit 38 and bit 23. Address bit 11 appears at bit 26. Address bits 13:12 appear at bits 17:16. Bits 24 and 2 are always 1. Bit 1 is 1 for a write and 0 for a read. All other bits are 0.
- R3: Port register codes on `port_sel` are: command = 0, low data = 1, high data = 2. An in-range write runs for six cycles after acceptance. These are, in order: a write of the data's low half to code 1, a write of the high half to code 2, a write of the command word to code 0, an idle gap, a write of zero to code 0, and an idle gap.
- R4: An in-range read runs for six cycles after acceptance. These are, in order: a write of the command word to code 0, an idle gap, a read of code 1 (taken as result bits 31:0), a read of code 2 (taken as result bits 63:32), a write of zero to code 0, and an idle gap.
- R5: The last command-register write of every transaction is zero, so the command register holds zero whenever `rsp_done` is asserted.
- R6: A write whose address is at or above `REGION_END` causes no port access. `rsp_done` pulses in the next cycle with `rsp_rdata` equal to 0.
- R7: A read whose address is strictly above `REGION_END` causes no port access. `rsp_done` pulses in the next cycle with `rsp_rdata` equal to 0. A read exactly at `REGION_END` is carried out in full.
- R8: `req_ready` is 1 only while idle. A request presented while a sequence is running has no effect on that sequence, and it is not accepted afterwards unless it is still presented once the block is idle.
- R9: For an in-range transaction, `rsp_done` is a one-cycle pulse in the seventh cycle after acceptance. `rsp_rdata` then holds the read result, or 0 after a write, until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the 64-bit word |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Sequencer idle; a valid request is taken this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read result (0 after a write or a skipped access) |
| port_wr | output | 1 | Test-port register write strobe |
| port_rd | output | 1 | Test-port register read strobe |
| port_sel | output | 2 | Register code: 0 command, 1 low data, 2 high data |
| port_wdata | output | 40 | Value written to the selected register |
| port_rdata | input | 32 | Value of the selected data register |

## Verification
The checker assumes that `port_rdata` reflects the selected data register within the same cycle. It also assumes that `REGION_END` stays fixed for the run, since the range properties recompute the limit test from the request ports. The bench draws addresses from a band that runs slightly past the limit, so that both sides of each comparison occur. It presents unrelated requests only while a sequence is running, and withdraws them before the sequencer returns to idle. Its behavioural port model decodes the command word back into a word index independently, so a scrambled encoding shows up as wrong read data as well as a wrong command value.

// File: rtl/wps_pkg.sv
package wps_pkg;
    localparam int HALF_W = 32;
    localparam int WORD_W = 2 * HALF_W;
    localparam int CMD_W  = 40;

    typedef enum logic [1:0] {
        SEL_CMD = 2'd0,
        SEL_LO  = 2'd1,
        SEL_HI  = 2'd2
    } port_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUT_LO,
        ST_PUT_HI,
        ST_ISSUE,
        ST_GAP_ISSUE,
        ST_GET_LO,
        ST_GET_HI,
        ST_CLEAR,
        ST_GAP_CLEAR
    } seq_state_e;
endpackage

// File: rtl/wps_cmd_enc.sv
module wps_cmd_enc
    import wps_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic [CMD_W-1:0]  cmd
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:16], addr[2:0]};

    always_comb begin
        cmd        = '0;
        cmd[10:3]  = addr[10:3];
        cmd[14]    = addr[14];
        cmd[17:16] = addr[13:12];
        cmd[26]    = addr[11];
        cmd[23]    = addr[15];
        cmd[38]    = addr[15];
        cmd[24]    = 1'b1;
        cmd[2]     = 1'b1;
        cmd[1]     = is_write;
    end
endmodule

// File: rtl/wps_limit.sv
module wps_limit #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] REGION_END = 'h0000_C000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              allowed
);
    always_comb begin
        if (is_write) allowed = (addr <  REGION_END);
        else          allowed = (addr <= REGION_END);
    end
endmodule

// File: rtl/wide_port_seq.sv
module wide_port_seq
    import wps_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] REGION_END = 'h0000_C000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              port_wr,
    output logic              port_rd,
    output logic [1:0]        port_sel,
    output logic [CMD_W-1:0]  port_wdata,
    input  logic [HALF_W-1:0] port_rdata
);
    localparam int PAD_W = CMD_W - HALF_W;

    typedef struct packed {
        seq_state_e        st;
        logic              is_wr;
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] cap;
        logic [WORD_W-1:0] rdata;
        logic              done;
    } seq_regs_t;

    seq_regs_t        seq_d, seq_q;
    logic [CMD_W-1:0] enc_cmd;
    logic             in_region;

    wps_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
        .addr     (req_addr),
        .is_write (req_write),
        .cmd      (enc_cmd)
    );

    wps_limit #(.ADDR_W(ADDR_W), .REGION_END(REGION_END)) u_limit (
        .addr     (req_addr),
        .is_write (req_write),
        .allowed  (in_region)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (in_region) begin
                        seq_d.cmd   = enc_cmd;
                        seq_d.wdata = req_wdata;
                        seq_d.is_wr = req_write;
                        seq_d.st    = req_write ? ST_PUT_LO : ST_ISSUE;
                    end else begin
                        seq_d.done  = 1'b1;
                        seq_d.rdata = '0;
                    end
                end
            end
            ST_PUT_LO:    seq_d.st = ST_PUT_HI;
            ST_PUT_HI:    seq_d.st = ST_ISSUE;
            ST_ISSUE:     seq_d.st = ST_GAP_ISSUE;
            ST_GAP_ISSUE: seq_d.st = seq_q.is_wr ? ST_CLEAR : ST_GET_LO;
            ST_GET_LO: begin
                seq_d.cap[HALF_W-1:0] = port_rdata;
                seq_d.st              = ST_GET_HI;
            end
            ST_GET_HI: begin
                seq_d.cap[WORD_W-1:HALF_W] = port_rdata;
                seq_d.st                   = ST_CLEAR;
            end
            ST_CLEAR:     seq_d.st = ST_GAP_CLEAR;
            ST_GAP_CLEAR: begin
                seq_d.done  = 1'b1;
                seq_d.rdata = seq_q.is_wr ? '0 : seq_q.cap;
                seq_d.st    = ST_IDLE;
            end
            default:      seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        port_wr    = 1'b0;
        port_rd    = 1'b0;
        port_sel   = SEL_CMD;
        port_wdata = '0;
        case (seq_q.st)
            ST_PUT_LO: begin
                port_wr    = 1'b1;
                port_sel   = SEL_LO;
                port_wdata = {{PAD_W{1'b0}}, seq_q.wdata[HALF_W-1:0]};
            end
            ST_PUT_HI: begin
                port_wr    = 1'b1;
                port_sel   = SEL_HI;
                port_wdata = {{PAD_W{1'b0}}, seq_q.wdata[WORD_W-1:HALF_W]};
            end
            ST_ISSUE: begin
                port_wr    = 1'b1;
                port_wdata = seq_q.cmd;
            end
            ST_GET_LO: begin
                port_rd  = 1'b1;
                port_sel = SEL_LO;
            end
            ST_GET_HI: begin
                port_rd  = 1'b1;
                port_sel = SEL_HI;
            end
            ST_CLEAR:  port_wr = 1'b1;
            default: ;
        endcase
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign rsp_done  = seq_q.done;
    assign rsp_rdata = seq_q.rdata;
endmodule

// File: rtl/wps_checker.sv
module wps_checker
    import wps_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] REGION_END = 'h0000_C000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [WORD_W-1:0] rsp_rdata,
    input logic              port_wr,
    input logic              port_rd,
    input logic [1:0]        port_sel,
    input logic [CMD_W-1:0]  port_wdata
);
    logic cmd_dirty;
    logic cmd_put;

    assign cmd_put = port_wr && (port_sel == 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmd_dirty <= 1'b0;
        else if (cmd_put) cmd_dirty <= (port_wdata != '0);
    end

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr || port_rd) |-> !req_ready);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R5
    cmd_left_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !cmd_dirty);

    // R3
    issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_put && port_wdata != '0) |=> !(port_wr || port_rd));

    // R2
    cmd_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_put && port_wdata != '0) |->
            (port_wdata[24] && port_wdata[2] && (port_wdata[38] == port_wdata[23])));

    // R4
    read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |-> (port_sel != 2'd0) && !port_wr);

    // R6
    write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_addr >= REGION_END) |=>
            (rsp_done && !port_wr && !port_rd && rsp_rdata == '0));

    // R7
    read_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_addr > REGION_END) |=>
            (rsp_done && !port_wr && !port_rd && rsp_rdata == '0));
endmodule

bind wide_port_seq wps_checker #(.ADDR_W(ADDR_W), .REGION_END(REGION_END)) u_wps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .port_wr    (port_wr),
    .port_rd    (port_rd),
    .port_sel   (port_sel),
    .port_wdata (port_wdata)
);

// File: tb/wide_port_seq_bench.sv
module wide_port_seq_bench;
    localparam logic [31:0] END_A = 32'h0000_C000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_done, port_wr, port_rd;
    logic [63:0] rsp_rdata;
    logic [1:0]  port_sel;
    logic [39:0] port_wdata;
    logic [31:0] port_rdata;

    int checks = 0;
    int errs = 0;

    always #10 clk = ~clk;

    wide_port_seq #(.ADDR_W(32), .REGION_END(END_A)) u_wide_port_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .port_wr(port_wr),
        .port_rd(port_rd), .port_sel(port_sel), .port_wdata(port_wdata),
        .port_rdata(port_rdata)
    );

    // behavioural test-port model: decodes the command word on its own
    logic [39:0] stub_cmd = '0;
    logic [31:0] stub_lo = '0;
    logic [31:0] stub_hi = '0;
    logic [63:0] stub_mem [logic [12:0]];
    logic [63:0] ref_mem  [logic [12:0]];

    function automatic logic [12:0] cmd_index(input logic [39:0] c);
        return {c[38], c[14], c[17:16], c[26], c[10:3]};
    endfunction

    always @(posedge clk) begin
        if (port_wr) begin
            case (port_sel)
                2'd1: stub_lo <= port_wdata[31:0];
                2'd2: stub_hi <= port_wdata[31:0];
                default: begin
                    stub_cmd <= port_wdata;
                    if (port_wdata != '0) begin
                        if (port_wdata[1]) stub_mem[cmd_index(port_wdata)] = {stub_hi, stub_lo};
                        else if (stub_mem.exists(cmd_index(port_wdata)))
                            {stub_hi, stub_lo} <= stub_mem[cmd_index(port_wdata)];
                        else {stub_hi, stub_lo} <= '0;
                    end
                end
            endcase
        end
    end

    assign port_rdata = (port_sel == 2'd2) ? stub_hi : stub_lo;

    function automatic logic [39:0] exp_cmd(input logic [31:0] a, input bit w);
        logic [39:0] c = '0;
        c[10:3] = a[10:3];  c[14] = a[14];  c[17:16] = a[13:12];
        c[26] = a[11];      c[23] = a[15];  c[38] = a[15];
        c[24] = 1'b1;       c[2] = 1'b1;    c[1] = w;
        return c;
    endfunction

    function automatic logic [63:0] ref_read(input logic [31:0] a);
        if (ref_mem.exists(a[15:3])) return ref_mem[a[15:3]];
        return '0;
    endfunction

    // {wr, rd, sel, wdata, ready, done}
    function automatic logic [45:0] exp_op(input bit w, input int k,
                                           input logic [31:0] a, input logic [63:0] d);
        if (w) begin
            case (k)
                0: return {1'b1, 1'b0, 2'd1, 8'h0, d[31:0], 2'b00};
                1: return {1'b1, 1'b0, 2'd2, 8'h0, d[63:32], 2'b00};
                2: return {1'b1, 1'b0, 2'd0, exp_cmd(a, 1'b1), 2'b00};
                4: return {1'b1, 1'b0, 2'd0, 40'h0, 2'b00};
                default: return '0;
            endcase
        end else begin
            case (k)
                0: return {1'b1, 1'b0, 2'd0, exp_cmd(a, 1'b0), 2'b00};
                2: return {1'b0, 1'b1, 2'd1, 40'h0, 2'b00};
                3: return {1'b0, 1'b1, 2'd2, 40'h0, 2'b00};
                4: return {1'b1, 1'b0, 2'd0, 40'h0, 2'b00};
                default: return '0;
            endcase
        end
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_txn(input bit w, input logic [31:0] a, input logic [63:0] d, input bit junk);
        bit ok;
        logic [63:0] expd;
        ok = w ? (a < END_A) : (a <= END_A);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        chk("R8 ready while idle", {63'b0, req_ready}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        if (junk && ok) begin
            req_write = ~w; req_addr = $urandom % END_A; req_wdata = {$urandom, $urandom};
        end else begin
            req_valid = 1'b0;
        end
        if (!ok) begin
            chk(w ? "R6 dropped write done/rdata" : "R7 far read done/rdata",
                {rsp_done, port_wr, port_rd, rsp_rdata[60:0]}, {3'b100, 61'd0});
            @(negedge clk);
            chk(w ? "R6 no later port access" : "R7 no later port access",
                {62'b0, port_wr, port_rd}, 64'd0);
            return;
        end
        for (int k = 0; k < 6; k++) begin
            chk(w ? "R3 write cycle op" : "R4 read cycle op",
                {18'b0, port_wr, port_rd, port_sel, port_wdata, req_ready, rsp_done},
                {18'b0, exp_op(w, k, a, d)});
            if (k == 5) req_valid = 1'b0;
            else @(negedge clk);
        end
        expd = w ? 64'd0 : ref_read(a);
        if (w) ref_mem[a[15:3]] = d;
        @(negedge clk);
        chk("R9 done pulse", {63'b0, rsp_done}, 64'd1);
        chk(w ? "R9 rdata after write" : "R4 read data", rsp_rdata, expd);
        chk("R5 command register zero at done", {24'b0, stub_cmd}, 64'd0);
        @(negedge clk);
        chk("R8 R9 idle after done, junk ignored",
            {60'b0, rsp_done, port_wr, port_rd, req_ready}, 64'd1);
        chk("R9 rdata held", rsp_rdata, expd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        stub_mem[13'h1800] = 64'hC0DE_0000_FACE_0001;
        ref_mem[13'h1800]  = 64'hC0DE_0000_FACE_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset state", {rsp_rdata[59:0], req_ready, rsp_done, port_wr, port_rd},
            {60'd0, 4'b1000});
        chk("R1 reset rdata upper", {60'd0, rsp_rdata[63:60]}, 64'd0);

        // R2 R3 R4 directed
        do_txn(1'b1, 32'h0000_0010, 64'h1122_3344_5566_7788, 1'b0);
        do_txn(1'b0, 32'h0000_0010, 64'd0, 1'b0);
        do_txn(1'b1, 32'h0000_BFF8, 64'hA5A5_0F0F_DEAD_BEEF, 1'b1);
        do_txn(1'b0, 32'h0000_BFF8, 64'd0, 1'b1);
        do_txn(1'b1, 32'h0000_8800, 64'h0000_0001_8000_0000, 1'b0);
        do_txn(1'b1, 32'h0000_3000, 64'hFFFF_FFFF_0000_0000, 1'b0);
        do_txn(1'b0, 32'h0000_8800, 64'd0, 1'b0);
        do_txn(1'b0, 32'h0000_3000, 64'd0, 1'b0);
        // R6 / R7 boundaries
        do_txn(1'b1, END_A, 64'h1234_5678_9ABC_DEF0, 1'b0);
        do_txn(1'b0, END_A, 64'd0, 1'b0);
        do_txn(1'b0, END_A + 32'd8, 64'd0, 1'b0);
        do_txn(1'b1, END_A + 32'd8, 64'h0BAD_0BAD_0BAD_0BAD, 1'b0);
        do_txn(1'b0, END_A, 64'd0, 1'b0);
        do_txn(1'b1, END_A - 32'd8, 64'h0F1E_2D3C_4B5A_6978, 1'b0);
        do_txn(1'b0, END_A - 32'd8, 64'd0, 1'b0);

        for (int i = 0; i < 120; i++) begin
            logic [31:0] ra;
            ra = $urandom % (END_A + 32'h10);
            if (i % 4 == 0) ra = ra & 32'hFFFF_FF3F;
            do_txn(1'($urandom % 2), ra, {$urandom, $urandom}, 1'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule